// File: doc/BRIEF.md
# Flagged Add-Subtract Unit

A purely combinational 32-bit arithmetic unit that takes a destination word, a source word, the current zero and carry flags and a four-bit operation code. It returns a result word, a write enable that tells the surrounding datapath whether the destination should be updated, and new zero and carry flags. One shared adder serves every add and subtract variant, and one comparator serves the clamp operations.

The operation family covers plain and carry-extended add and subtract, add-or-subtract chosen by a flag, reverse subtract, subtract-only-if-not-below, and unsigned and signed clamping. Extended forms chain the zero flag, so a multi-word compare or subtract reports zero only when every word was zero. Conditional sums report signed overflow in the carry flag. There is no clock and no state: outputs follow the inputs in the same cycle. Because the unit is a single combinational stage, it has no valid/ready edge; the caller registers around it.

Top module: `flagged_addsub`

## Requirements
- R1: Opcodes on `op_sel` are 0 add, 1 sub, 2 add-extended, 3 sub-extended, 4 sum-by-C, 5 sum-by-not-C, 6 sum-by-Z, 7 sum-by-not-Z, 8 compare-subtract, 9 reverse-subtract, 10 unsigned-min, 11 unsigned-max, 12 signed-min, 13 signed-max. Add gives D+S with C the unsigned carry out; sub gives D-S with C set when S > D unsigned.
- R2: For every non-extended operation, Z is 1 exactly when `res_out` is zero.
- R3: Add-extended gives D+S+C_in with C the carry out; sub-extended gives D-S-C_in with C set when S+C_in exceeds D unsigned; both give Z = Z_in AND (result == 0).
- R4: Sum-by-C gives D-S when C_in is 1 and D+S when it is 0; sum-by-Z does the same keyed by Z_in; the not-forms invert the key.
- R5: For the four conditional sums, C is 1 exactly when the signed result falls outside the signed 32-bit range.
- R6: Compare-subtract gives D-S with `wr_en` 1 when D >= S unsigned, else `res_out` = D with `wr_en` 0; C reports D >= S.
- R7: Reverse-subtract gives S-D with C set when D > S unsigned.
- R8: Unsigned-min loads S (wr_en 1) when D < S unsigned; unsigned-max loads S when D >= S unsigned; otherwise `res_out` = D with `wr_en` 0.
- R9: Signed-min and signed-max behave as in R8 with a two's-complement comparison.
- R10: For the four clamp operations, C reports D < S (in the operation's signedness) and Z reports D == S.
- R11: Operations 0 to 7, 9 always assert `wr_en`; codes 14 and 15 give `res_out` = D, `wr_en` 0, and pass Z_in and C_in through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| d_in | input | 32 | Destination operand |
| s_in | input | 32 | Source operand |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| res_out | output | 32 | Result word |
| wr_en | output | 1 | Destination should be written |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |

## Verification
Random operands and flags across all sixteen codes exercise the general mix, while directed vectors pin the edges: operands equal to each other separate the >= from the < side of compare-subtract and the clamps, sign-bit-set operands separate signed from unsigned clamps, and the most negative value in a conditional subtract separates true signed overflow from a carry-based guess. Extended operations are fed a zero result with Z_in both high and low to show the chaining, and carry-in of 1 on all-ones operands shows the carry travels through the full width.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_ADDX   = 4'd2,
    OP_SUBX   = 4'd3,
    OP_SUMC   = 4'd4,
    OP_SUMNC  = 4'd5,
    OP_SUMZ   = 4'd6,
    OP_SUMNZ  = 4'd7,
    OP_CMPSUB = 4'd8,
    OP_SUBR   = 4'd9,
    OP_MINU   = 4'd10,
    OP_MAXU   = 4'd11,
    OP_MINS   = 4'd12,
    OP_MAXS   = 4'd13,
    OP_RSV14  = 4'd14,
    OP_RSV15  = 4'd15
  } op_e;
endpackage

// File: rtl/sum_core.sv
module sum_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] bx;
  logic [W:0]   wide;

  assign bx   = inv_b_i ? ~b_i : b_i;
  assign wide = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cin_i};
  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  // Two operands of like sign giving a sum of the other sign.
  assign ovf_o  = (a_i[W-1] == bx[W-1]) && (wide[W-1] != a_i[W-1]);
endmodule

// File: rtl/mag_compare.sv
module mag_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic         lt_u_o,
  output logic         lt_s_o,
  output logic         eq_o
);
  assign lt_u_o = x_i < y_i;
  assign lt_s_o = $signed(x_i) < $signed(y_i);
  assign eq_o   = x_i == y_i;
endmodule

// File: rtl/flagged_addsub.sv
module flagged_addsub
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] s_in,
  input  logic         z_in,
  input  logic         c_in,
  output logic [W-1:0] res_out,
  output logic         wr_en,
  output logic         z_out,
  output logic         c_out
);
  localparam logic [W-1:0] ZERO = '0;

  op_e op;
  assign op = op_e'(op_sel);

  logic [W-1:0] opa, opb, sum;
  logic         inv_b, cin, cout, ovf;
  logic         lt_u, lt_s, eq;
  logic         sum_zero;

  // Operand steering for the shared adder.
  always_comb begin
    opa   = d_in;
    opb   = s_in;
    inv_b = 1'b0;
    cin   = 1'b0;
    case (op)
      OP_SUB, OP_CMPSUB: begin inv_b = 1'b1; cin = 1'b1; end
      OP_ADDX:           cin = c_in;
      OP_SUBX:           begin inv_b = 1'b1; cin = ~c_in; end
      OP_SUMC:           begin inv_b = c_in;  cin = c_in;  end
      OP_SUMNC:          begin inv_b = ~c_in; cin = ~c_in; end
      OP_SUMZ:           begin inv_b = z_in;  cin = z_in;  end
      OP_SUMNZ:          begin inv_b = ~z_in; cin = ~z_in; end
      OP_SUBR:           begin opa = s_in; opb = d_in; inv_b = 1'b1; cin = 1'b1; end
      default: ;
    endcase
  end

  sum_core #(.W(W)) u_sum (
    .a_i(opa), .b_i(opb), .inv_b_i(inv_b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  mag_compare #(.W(W)) u_cmp (
    .x_i(d_in), .y_i(s_in), .lt_u_o(lt_u), .lt_s_o(lt_s), .eq_o(eq)
  );

  assign sum_zero = (sum == ZERO);

  // Result, write enable and flag selection.
  always_comb begin
    res_out = sum;
    wr_en   = 1'b1;
    z_out   = sum_zero;
    c_out   = cout;
    case (op)
      OP_ADD: ;
      OP_SUB, OP_SUBR: c_out = ~cout;
      OP_ADDX: z_out = z_in & sum_zero;
      OP_SUBX: begin c_out = ~cout; z_out = z_in & sum_zero; end
      OP_SUMC, OP_SUMNC, OP_SUMZ, OP_SUMNZ: c_out = ovf;
      OP_CMPSUB: begin
        wr_en   = cout;
        res_out = cout ? sum : d_in;
        z_out   = cout ? sum_zero : (d_in == ZERO);
        c_out   = cout;
      end
      OP_MINU: begin
        wr_en = lt_u;  res_out = lt_u ? s_in : d_in;  c_out = lt_u; z_out = eq;
      end
      OP_MAXU: begin
        wr_en = ~lt_u; res_out = lt_u ? d_in : s_in;  c_out = lt_u; z_out = eq;
      end
      OP_MINS: begin
        wr_en = lt_s;  res_out = lt_s ? s_in : d_in;  c_out = lt_s; z_out = eq;
      end
      OP_MAXS: begin
        wr_en = ~lt_s; res_out = lt_s ? d_in : s_in;  c_out = lt_s; z_out = eq;
      end
      default: begin
        wr_en = 1'b0; res_out = d_in; z_out = z_in; c_out = c_in;
      end
    endcase
  end

  // Checks relating the adder, comparator and selection logic.
  always_comb begin
    if (!wr_en) begin
      p_hold_dest_r6: assert (res_out == d_in);
    end
    if (op == OP_ADDX || op == OP_SUBX) begin
      p_zero_chain_r3: assert (!z_out || z_in);
    end
    if (op == OP_MINU || op == OP_MAXU || op == OP_MINS || op == OP_MAXS) begin
      p_eq_not_lt_r10: assert (!(z_out && c_out));
    end
    if (op == OP_CMPSUB) begin
      p_ge_writes_r6: assert (c_out == wr_en);
    end
    if (op == OP_ADD) begin
      p_carry_wrap_r1: assert (c_out == (res_out < d_in));
    end
  end
endmodule

// File: tb/sim_flagged_addsub.sv
module sim_flagged_addsub;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]   op_sel;
  logic [W-1:0] d_in, s_in, res_out;
  logic         z_in, c_in, wr_en, z_out, c_out;

  flagged_addsub #(.W(W)) u0 (
    .op_sel(op_sel), .d_in(d_in), .s_in(s_in), .z_in(z_in), .c_in(c_in),
    .res_out(res_out), .wr_en(wr_en), .z_out(z_out), .c_out(c_out)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:               return "R1/R2";
      4'd2, 4'd3:               return "R3";
      4'd4, 4'd5, 4'd6, 4'd7:   return "R4/R5";
      4'd8:                     return "R6";
      4'd9:                     return "R7";
      4'd10, 4'd11:             return "R8/R10";
      4'd12, 4'd13:             return "R9/R10";
      default:                  return "R11";
    endcase
  endfunction

  // Reference model: returns {res, wr, z, c}.
  function automatic logic [W+2:0] model(input logic [3:0] op, input logic [W-1:0] d,
                                         input logic [W-1:0] s, input logic zi, input logic ci);
    logic [W-1:0] r; logic wr, z, c, neg;
    longint unsigned ud, us, t;
    longint sd, ss, st;
    ud = longint'(d); us = longint'(s);
    sd = longint'($signed(d)); ss = longint'($signed(s));
    wr = 1'b1; r = '0; z = 1'b0; c = 1'b0;
    case (op)
      4'd0: begin t = ud + us; r = t[W-1:0]; c = t[W]; z = (r == 0); end
      4'd1: begin r = d - s; c = ud < us; z = (r == 0); end
      4'd2: begin t = ud + us + longint'(ci); r = t[W-1:0]; c = t[W]; z = zi && (r == 0); end
      4'd3: begin r = d - s - {31'd0, ci}; c = ud < (us + longint'(ci)); z = zi && (r == 0); end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        neg = (op == 4'd4) ? ci : (op == 4'd5) ? !ci : (op == 4'd6) ? zi : !zi;
        st = neg ? sd - ss : sd + ss;
        r = st[W-1:0];
        c = (st > 64'sd2147483647) || (st < -64'sd2147483648);
        z = (r == 0);
      end
      4'd8: begin
        wr = ud >= us; r = wr ? d - s : d; c = wr; z = (r == 0);
      end
      4'd9: begin r = s - d; c = ud > us; z = (r == 0); end
      4'd10: begin wr = ud < us;  r = wr ? s : d; c = ud < us; z = d == s; end
      4'd11: begin wr = ud >= us; r = wr ? s : d; c = ud < us; z = d == s; end
      4'd12: begin wr = sd < ss;  r = wr ? s : d; c = sd < ss; z = d == s; end
      4'd13: begin wr = sd >= ss; r = wr ? s : d; c = sd < ss; z = d == s; end
      default: begin wr = 1'b0; r = d; z = zi; c = ci; end
    endcase
    return {r, wr, z, c};
  endfunction

  task automatic apply(input logic [3:0] op, input logic [W-1:0] d, input logic [W-1:0] s,
                       input logic zi, input logic ci);
    logic [W+2:0] exp, got;
    op_sel = op; d_in = d; s_in = s; z_in = zi; c_in = ci;
    @(negedge clk);
    exp = model(op, d, s, zi, ci);
    got = {res_out, wr_en, z_out, c_out};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d d=%h s=%h z=%b c=%b: got res=%h wr=%b z=%b c=%b, expected res=%h wr=%b z=%b c=%b",
               req_of(op), op, d, s, zi, ci, got[W+2:3], got[2], got[1], got[0],
               exp[W+2:3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin
    op_sel = 4'd0; d_in = '0; s_in = '0; z_in = 1'b0; c_in = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Idle inputs: add of zeros gives zero with Z set (R1, R2).
    apply(4'd0, 32'h0, 32'h0, 1'b0, 1'b0);
    // R1: carry out and borrow.
    apply(4'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
    apply(4'd1, 32'h5, 32'h6, 1'b1, 1'b0);
    apply(4'd1, 32'h6, 32'h6, 1'b0, 1'b1);
    // R3: carry through full width, Z chaining both ways.
    apply(4'd2, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1);
    apply(4'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1);
    apply(4'd3, 32'h1, 32'h0, 1'b1, 1'b1);
    apply(4'd3, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b1);
    // R4/R5: most-negative source, overflow edges.
    apply(4'd4, 32'h0, 32'h8000_0000, 1'b0, 1'b1);
    apply(4'd5, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b0);
    apply(4'd6, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0);
    apply(4'd7, 32'h8000_0000, 32'h1, 1'b0, 1'b0);
    // R6: equal, below, above.
    apply(4'd8, 32'h10, 32'h10, 1'b0, 1'b0);
    apply(4'd8, 32'h0F, 32'h10, 1'b1, 1'b1);
    apply(4'd8, 32'h20, 32'h10, 1'b0, 1'b0);
    // R7
    apply(4'd9, 32'h3, 32'h2, 1'b0, 1'b0);
    apply(4'd9, 32'h2, 32'h2, 1'b0, 1'b0);
    // R8/R9/R10: equal operands and sign-bit operands.
    for (int op = 10; op <= 13; op++) begin
      apply(4'(op), 32'h1234, 32'h1234, 1'b0, 1'b0);
      apply(4'(op), 32'h8000_0000, 32'h1, 1'b0, 1'b0);
      apply(4'(op), 32'h1, 32'h8000_0000, 1'b1, 1'b1);
    end
    // R11: reserved codes pass flags through.
    apply(4'd14, 32'hDEAD_BEEF, 32'h1, 1'b1, 1'b0);
    apply(4'd15, 32'h0, 32'h1, 1'b0, 1'b1);
    // Random mix over all codes, fixed seed.
    void'($urandom(32'd1729));
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] rd, rs;
      rd = $urandom();
      rs = ($urandom() % 8 == 0) ? rd : $urandom();
      apply(4'($urandom() % 16), rd, rs, 1'($urandom()), 1'($urandom()));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule